// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit fixed-point signal processor. Each cycle it can take two 16-bit operands, mark each one independently as signed or unsigned, and form their exact product. It then adds that product to one of six 40-bit accumulators, or subtracts it from one. Two further modes skip the multiplier: the two operands are joined into one 32-bit word, which is added to or subtracted from the selected accumulator. The source and destination accumulators are chosen separately, so any entry can feed any other.

The 40-bit accumulators carry eight guard bits above a 32-bit working range. An overflow flag reports a result that no longer fits in 40 signed bits. An optional clamp limits a written-back result to the 32-bit signed range and reports that it did so. A second write port lets the surrounding core load an accumulator directly. A separate read port lets it observe any accumulator.

Top module: `mac_unit`

## Requirements
- R1: After reset every accumulator reads zero, and resValid, ovfFlag and satFlag are low.
- R2: Operand A is sign-extended when aSigned is 1 and zero-extended when it is 0. Operand B is treated the same way under bSigned. The product is exact for all four sign pairings, and it is sign-extended to 40 bits before accumulation.
- R3: opSel 0 writes acc[srcIdx] + product to acc[dstIdx]. opSel 1 writes acc[srcIdx] − product.
- R4: opSel 2 and opSel 3 bypass the multiplier. They add (2) or subtract (3) the 32-bit word {opA, opB}, with opA in bits 31:16. The word is sign-extended to 40 bits when aSigned is 1 and zero-extended otherwise. bSigned has no effect in these modes.
- R5: The result appears on resData with resValid high one clock edge after inValid is sampled high, and the destination is written on that same edge. A read of an accumulator in the cycle it is being written returns the old value.
- R6: ovfFlag is set with a result whose exact sum lies outside the 40-bit signed range. In that case the stored value is the sum wrapped to 40 bits, unless R7 clamps it.
- R7: When satEn is 1 and the exact sum exceeds 0x00_7FFF_FFFF or lies below 0xFF_8000_0000, the result is clamped to that bound and satFlag is set. With satEn at 0, no clamping takes place.
- R8: Write port 0 is the computed result and write port 1 is the load port (ldValid, ldIdx, ldData). When both ports target the same accumulator in one cycle, port 0 wins. When they target different accumulators, both writes happen.
- R9: Indices 6 and 7 name no accumulator. A write to either is dropped, and a read of either, as source or on rdIdx, returns zero.
- R10: In a cycle with inValid low, resValid, ovfFlag and satFlag fall low, resData holds its last value, and no accumulator is written except through the load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation request this cycle |
| opA | input | 16 | First operand (upper half of the word in add/sub modes) |
| opB | input | 16 | Second operand (lower half of the word in add/sub modes) |
| aSigned | input | 1 | Operand A (or the 32-bit word) is signed |
| bSigned | input | 1 | Operand B is signed |
| opSel | input | 2 | 0 multiply-add, 1 multiply-subtract, 2 add, 3 subtract |
| srcIdx | input | 3 | Accumulator read as the addend |
| dstIdx | input | 3 | Accumulator receiving the result |
| satEn | input | 1 | Clamp the result to the 32-bit signed range |
| ldValid | input | 1 | Direct load request |
| ldIdx | input | 3 | Accumulator to load |
| ldData | input | 40 | Value to load |
| rdIdx | input | 3 | Accumulator to observe |
| rdData | output | 40 | Current contents of acc[rdIdx] |
| resValid | output | 1 | resData holds a fresh result |
| resData | output | 40 | Last result written back |
| ovfFlag | output | 1 | Last result overflowed 40 bits |
| satFlag | output | 1 | Last result was clamped |

## Verification
The bench drives the four sign pairings with 0xFFFF and 0x8000 operands. A design that extends every operand the same way gives products off by a multiple of 2^16 there. It forces a carry out of the guard bits from 0x7F_FFFF_FFFF, and it clamps just past both 32-bit bounds. Swapping the clamp limits or taking the sign from the wrapped sum shows up at these points. It also aims a computed write and a load at the same accumulator, and it reads an entry in the cycle it is written, which catches an inverted port priority or a forwarding path. Last, it uses indices 6 and 7, where an unguarded decoder would alias onto real entries.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int DATA_W  = 16;
  parameter int GUARD_W = 8;
  parameter int ACC_W   = 2 * DATA_W + GUARD_W;
  parameter int NUM_ACC = 6;
  parameter int IDX_W   = $clog2(NUM_ACC + 2);

  typedef enum logic [1:0] {
    OP_MAC = 2'd0,
    OP_MSU = 2'd1,
    OP_ADD = 2'd2,
    OP_SUB = 2'd3
  } macOp_e;

  typedef struct packed {
    logic fire;
    logic useMul;
    logic negate;
    logic clampEn;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int NUM_E = NUM_ACC,
  parameter int IW    = IDX_W
) (
  input  logic          inValid,
  input  logic [1:0]    opSel,
  input  logic          satEn,
  input  logic [IW-1:0] dstIdx,
  output macStrobe_t    strobe,
  output logic          wrEn
);
  macOp_e op;
  assign op = macOp_e'(opSel);

  always_comb begin
    strobe.fire    = inValid;
    strobe.useMul  = (op == OP_MAC) || (op == OP_MSU);
    strobe.negate  = (op == OP_MSU) || (op == OP_SUB);
    strobe.clampEn = inValid && satEn;
    wrEn           = inValid && (dstIdx < IW'(NUM_E));
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int GW = GUARD_W,
  parameter int AW = ACC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  macStrobe_t    strobe,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic          aSigned,
  input  logic          bSigned,
  input  logic [AW-1:0] srcVal,
  output logic [AW-1:0] nextVal,
  output logic [AW-1:0] resData,
  output logic          resValid,
  output logic          ovfFlag,
  output logic          satFlag
);
  localparam int EXT_W  = DW + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int WORD_W = 2 * DW;
  localparam int SAT_W  = AW - GW;
  localparam int SUM_W  = AW + 1;
  localparam int TOP_W  = AW - SAT_W + 1;
  localparam logic [AW-1:0] MAX_V = {{(GW + 1){1'b0}}, {(SAT_W - 1){1'b1}}};
  localparam logic [AW-1:0] MIN_V = {{(GW + 1){1'b1}}, {(SAT_W - 1){1'b0}}};

  // operand extension: one extra bit chosen by the per-operand flag
  logic signed [EXT_W-1:0]  aExt, bExt;
  logic signed [PROD_W-1:0] prod;
  assign aExt = {aSigned & opA[DW-1], opA};
  assign bExt = {bSigned & opB[DW-1], opB};
  assign prod = aExt * bExt;

  logic [AW-1:0] prodTerm, wordTerm, term;
  assign prodTerm = {{(AW - PROD_W){prod[PROD_W-1]}}, prod};
  assign wordTerm = {{(AW - WORD_W){aSigned & opA[DW-1]}}, opA, opB};
  assign term     = strobe.useMul ? prodTerm : wordTerm;

  // one guard-extended adder serves all four modes
  logic [SUM_W-1:0] srcX, termX, sum;
  assign srcX  = {srcVal[AW-1], srcVal};
  assign termX = {term[AW-1], term};
  assign sum   = strobe.negate ? (srcX - termX) : (srcX + termX);

  logic wrapOvf, posOver, negOver, clampHi, clampLo;
  logic [TOP_W-1:0] topBits;
  assign topBits = sum[AW-1:SAT_W-1];
  assign wrapOvf = sum[SUM_W-1] ^ sum[AW-1];
  assign posOver = !sum[SUM_W-1] && (topBits != '0);
  assign negOver = sum[SUM_W-1] && (topBits != '1);
  assign clampHi = strobe.clampEn && posOver;
  assign clampLo = strobe.clampEn && negOver;

  always_comb begin
    if (clampHi)      nextVal = MAX_V;
    else if (clampLo) nextVal = MIN_V;
    else              nextVal = sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resData  <= '0;
      resValid <= 1'b0;
      ovfFlag  <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      resValid <= strobe.fire;
      if (strobe.fire) begin
        resData <= nextVal;
        ovfFlag <= wrapOvf;
        satFlag <= clampHi || clampLo;
      end else begin
        ovfFlag <= 1'b0;
        satFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mac_acc_file.sv
module mac_acc_file #(
  parameter int NUM_E  = 6,
  parameter int AW     = 40,
  parameter int IW     = 3,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_WR-1:0]            wrEn,
  input  logic [NUM_WR-1:0][IW-1:0]    wrIdx,
  input  logic [NUM_WR-1:0][AW-1:0]    wrData,
  input  logic [NUM_RD-1:0][IW-1:0]    rdIdx,
  output logic [NUM_RD-1:0][AW-1:0]    rdData
);
  logic [NUM_E-1:0][AW-1:0] accFlat;

  for (genvar e = 0; e < NUM_E; e++) begin : g_entry
    logic          hit;
    logic [AW-1:0] nxt;
    logic [AW-1:0] q;

    // scan from the highest port down so the lowest port is applied last
    always_comb begin
      hit = 1'b0;
      nxt = q;
      for (int p = NUM_WR - 1; p >= 0; p--) begin
        if (wrEn[p] && (wrIdx[p] == IW'(e))) begin
          hit = 1'b1;
          nxt = wrData[p];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    q <= '0;
      else if (hit) q <= nxt;
    end

    assign accFlat[e] = q;
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_read
    always_comb begin
      rdData[r] = '0;
      for (int i = 0; i < NUM_E; i++) begin
        if (rdIdx[r] == IW'(i)) rdData[r] = accFlat[i];
      end
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               aSigned,
  input  logic               bSigned,
  input  logic [1:0]         opSel,
  input  logic [IDX_W-1:0]   srcIdx,
  input  logic [IDX_W-1:0]   dstIdx,
  input  logic               satEn,
  input  logic               ldValid,
  input  logic [IDX_W-1:0]   ldIdx,
  input  logic [ACC_W-1:0]   ldData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [ACC_W-1:0]   rdData,
  output logic               resValid,
  output logic [ACC_W-1:0]   resData,
  output logic               ovfFlag,
  output logic               satFlag
);
  macStrobe_t strobe;
  logic       macWrEn;
  logic [ACC_W-1:0] nextVal;

  logic [1:0]              wrEnV;
  logic [1:0][IDX_W-1:0]   wrIdxV;
  logic [1:0][ACC_W-1:0]   wrDataV;
  logic [1:0][IDX_W-1:0]   rdIdxV;
  logic [1:0][ACC_W-1:0]   rdDataV;

  mac_ctrl #(.NUM_E(NUM_ACC), .IW(IDX_W)) u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .satEn   (satEn),
    .dstIdx  (dstIdx),
    .strobe  (strobe),
    .wrEn    (macWrEn)
  );

  mac_datapath #(.DW(DATA_W), .GW(GUARD_W), .AW(ACC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .aSigned  (aSigned),
    .bSigned  (bSigned),
    .srcVal   (rdDataV[0]),
    .nextVal  (nextVal),
    .resData  (resData),
    .resValid (resValid),
    .ovfFlag  (ovfFlag),
    .satFlag  (satFlag)
  );

  assign wrEnV   = {ldValid, macWrEn};
  assign wrIdxV  = {ldIdx, dstIdx};
  assign wrDataV = {ldData, nextVal};
  assign rdIdxV  = {rdIdx, srcIdx};
  assign rdData  = rdDataV[1];

  mac_acc_file #(
    .NUM_E(NUM_ACC), .AW(ACC_W), .IW(IDX_W), .NUM_WR(2), .NUM_RD(2)
  ) u_acc (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEnV),
    .wrIdx  (wrIdxV),
    .wrData (wrDataV),
    .rdIdx  (rdIdxV),
    .rdData (rdDataV)
  );
endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker
  import mac_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             satEn,
  input logic [IDX_W-1:0] rdIdx,
  input logic [ACC_W-1:0] rdData,
  input logic             resValid,
  input logic [ACC_W-1:0] resData,
  input logic             ovfFlag,
  input logic             satFlag
);
  localparam int SAT_W = ACC_W - GUARD_W;
  localparam logic [ACC_W-1:0] MAX_V = {{(GUARD_W + 1){1'b0}}, {(SAT_W - 1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_V = {{(GUARD_W + 1){1'b1}}, {(SAT_W - 1){1'b0}}};

  a_r5_result_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!resValid && !ovfFlag && !satFlag && $stable(resData)));

  a_r7_clamp_bound: assert property (@(posedge clk) disable iff (!rstN)
    satFlag |-> (resData == MAX_V || resData == MIN_V));

  a_r7_clamp_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && satFlag) |-> $past(satEn));

  a_r6_wrap_implies_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && ovfFlag && $past(satEn)) |-> satFlag);

  a_r9_missing_entry_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx >= IDX_W'(NUM_ACC)) |-> (rdData == '0));
endmodule

bind mac_unit mac_unit_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .satEn    (satEn),
  .rdIdx    (rdIdx),
  .rdData   (rdData),
  .resValid (resValid),
  .resData  (resData),
  .ovfFlag  (ovfFlag),
  .satFlag  (satFlag)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam longint MAX40 = 64'sd549755813887;
  localparam longint MIN40 = -64'sd549755813888;
  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        aSigned = 1'b0, bSigned = 1'b0;
  logic [1:0]  opSel = '0;
  logic [2:0]  srcIdx = '0, dstIdx = '0;
  logic        satEn = 1'b0;
  logic        ldValid = 1'b0;
  logic [2:0]  ldIdx = '0;
  logic [39:0] ldData = '0;
  logic [2:0]  rdIdx = '0;
  logic [39:0] rdData;
  logic        resValid;
  logic [39:0] resData;
  logic        ovfFlag, satFlag;

  int total = 0;
  int bad = 0;

  longint model [8];
  logic        expValid = 1'b0;
  logic [39:0] expData = '0;
  logic        expOvf = 1'b0, expSat = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .aSigned(aSigned), .bSigned(bSigned), .opSel(opSel), .srcIdx(srcIdx),
    .dstIdx(dstIdx), .satEn(satEn), .ldValid(ldValid), .ldIdx(ldIdx),
    .ldData(ldData), .rdIdx(rdIdx), .rdData(rdData), .resValid(resValid),
    .resData(resData), .ovfFlag(ovfFlag), .satFlag(satFlag)
  );

  function automatic longint accGet(input logic [2:0] i);
    return (i < 3'd6) ? model[i] : 64'sd0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input string tag, input bit v, input logic [15:0] a,
                      input logic [15:0] b, input bit as, input bit bs,
                      input logic [1:0] op, input logic [2:0] src,
                      input logic [2:0] dst, input bit sat, input bit ldv,
                      input logic [2:0] ldi, input logic [39:0] ldd,
                      input logic [2:0] rdi);
    longint srcV, term, sum, res;
    logic [31:0] word;
    logic [39:0] bits;
    bit ovf, clamp, macWr;
    inValid = v; opA = a; opB = b; aSigned = as; bSigned = bs; opSel = op;
    srcIdx = src; dstIdx = dst; satEn = sat; ldValid = ldv; ldIdx = ldi;
    ldData = ldd; rdIdx = rdi;
    #1;
    // same-cycle read sees the contents before this edge
    bits = accGet(rdi) [39:0];
    check(rdData == bits, tag, "rdData before edge", rdData, bits);
    srcV = accGet(src);
    word = {a, b};
    if (op < 2'd2)
      term = (as ? longint'($signed(a)) : longint'(a)) *
             (bs ? longint'($signed(b)) : longint'(b));
    else
      term = as ? longint'($signed(word)) : longint'(word);
    sum = (op == 2'd1 || op == 2'd3) ? srcV - term : srcV + term;
    ovf = (sum > MAX40) || (sum < MIN40);
    clamp = 1'b0;
    if (sat && sum > MAX32) begin res = MAX32; clamp = 1'b1; end
    else if (sat && sum < MIN32) begin res = MIN32; clamp = 1'b1; end
    else begin bits = sum[39:0]; res = longint'($signed(bits)); end
    @(posedge clk);
    macWr = v && (dst < 3'd6);
    if (macWr) model[dst] = res;
    if (ldv && ldi < 3'd6 && !(macWr && dst == ldi))
      model[ldi] = longint'($signed(ldd));
    expValid = v;
    if (v) begin expData = res[39:0]; expOvf = ovf; expSat = clamp; end
    else begin expOvf = 1'b0; expSat = 1'b0; end
    @(negedge clk);
    check(resValid == expValid, v ? "R5" : "R10", "resValid",
          40'(resValid), 40'(expValid));
    check(resData == expData, tag, "resData", resData, expData);
    check(ovfFlag == expOvf, "R6", "ovfFlag", 40'(ovfFlag), 40'(expOvf));
    check(satFlag == expSat, "R7", "satFlag", 40'(satFlag), 40'(expSat));
  endtask

  task automatic idle(input string tag, input bit ldv, input logic [2:0] ldi,
                      input logic [39:0] ldd, input logic [2:0] rdi);
    doOp(tag, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 1'b0,
         ldv, ldi, ldd, rdi);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of every entry and of the result flags
    check(!resValid && !ovfFlag && !satFlag, "R1", "flags after reset",
          {37'd0, resValid, ovfFlag, satFlag}, 40'd0);
    for (int i = 0; i < 8; i++) idle("R1", 1'b0, 3'd0, 40'd0, 3'(i));

    // R2: four sign pairings
    doOp("R2", 1, 16'hFFFF, 16'hFFFF, 1, 1, 2'd0, 3'd0, 3'd1, 0, 0, 0, 0, 3'd1);
    doOp("R2", 1, 16'hFFFF, 16'hFFFF, 1, 0, 2'd0, 3'd0, 3'd1, 0, 0, 0, 0, 3'd1);
    doOp("R2", 1, 16'hFFFF, 16'hFFFF, 0, 1, 2'd0, 3'd0, 3'd2, 0, 0, 0, 0, 3'd1);
    doOp("R2", 1, 16'hFFFF, 16'hFFFF, 0, 0, 2'd0, 3'd0, 3'd2, 0, 0, 0, 0, 3'd2);
    doOp("R2", 1, 16'h8000, 16'h8000, 1, 1, 2'd0, 3'd2, 3'd2, 0, 0, 0, 0, 3'd2);
    doOp("R2", 1, 16'h8000, 16'h7FFF, 1, 0, 2'd0, 3'd0, 3'd5, 0, 0, 0, 0, 3'd5);
    // R3: multiply-subtract, reading the entry being written returns old (R5)
    doOp("R3", 1, 16'h1234, 16'hFEDC, 1, 1, 2'd1, 3'd2, 3'd2, 0, 0, 0, 0, 3'd2);
    doOp("R3", 1, 16'hABCD, 16'h0042, 0, 1, 2'd0, 3'd2, 3'd0, 0, 0, 0, 0, 3'd0);
    doOp("R5", 1, 16'h0003, 16'h0005, 0, 0, 2'd0, 3'd0, 3'd0, 0, 0, 0, 0, 3'd0);
    // R4: plain add and subtract with both extension choices
    doOp("R4", 1, 16'hFFFF, 16'hFFFE, 1, 0, 2'd2, 3'd0, 3'd3, 0, 0, 0, 0, 3'd3);
    doOp("R4", 1, 16'hFFFF, 16'hFFFE, 0, 1, 2'd2, 3'd3, 3'd3, 0, 0, 0, 0, 3'd3);
    doOp("R4", 1, 16'h8000, 16'h0001, 1, 1, 2'd3, 3'd3, 3'd4, 0, 0, 0, 0, 3'd4);
    doOp("R4", 1, 16'h8000, 16'h0001, 0, 0, 2'd3, 3'd4, 3'd4, 0, 0, 0, 0, 3'd4);
    // R6: carry out of the guard bits
    idle("R6", 1, 3'd3, 40'h7F_FFFF_FFFF, 3'd3);
    doOp("R6", 1, 16'h0001, 16'h0001, 1, 1, 2'd0, 3'd3, 3'd3, 0, 0, 0, 0, 3'd3);
    doOp("R6", 1, 16'h0000, 16'h0001, 1, 1, 2'd3, 3'd3, 3'd3, 0, 0, 0, 0, 3'd3);
    // R7: clamp at both bounds, and no clamp when disabled or in range
    idle("R7", 1, 3'd4, 40'h00_7FFF_FFFF, 3'd4);
    doOp("R7", 1, 16'h0000, 16'h0001, 1, 1, 2'd2, 3'd4, 3'd4, 1, 0, 0, 0, 3'd4);
    doOp("R7", 1, 16'h0000, 16'h0001, 1, 1, 2'd2, 3'd4, 3'd5, 0, 0, 0, 0, 3'd5);
    idle("R7", 1, 3'd4, 40'hFF_8000_0000, 3'd4);
    doOp("R7", 1, 16'h0000, 16'h0001, 1, 1, 2'd3, 3'd4, 3'd4, 1, 0, 0, 0, 3'd4);
    doOp("R7", 1, 16'h0000, 16'h0001, 1, 1, 2'd2, 3'd4, 3'd4, 1, 0, 0, 0, 3'd4);
    idle("R7", 1, 3'd3, 40'h7F_FFFF_FFFF, 3'd3);
    doOp("R7", 1, 16'h0001, 16'h0001, 1, 1, 2'd0, 3'd3, 3'd3, 1, 0, 0, 0, 3'd3);
    // R8: write-port priority and independent writes
    doOp("R8", 1, 16'h0002, 16'h0003, 0, 0, 2'd0, 3'd0, 3'd2, 0,
         1, 3'd2, 40'h12_3456_789A, 3'd2);
    idle("R8", 0, 3'd0, 40'd0, 3'd2);
    doOp("R8", 1, 16'h0002, 16'h0003, 0, 0, 2'd0, 3'd0, 3'd1, 0,
         1, 3'd5, 40'hF0_0000_0001, 3'd5);
    idle("R8", 0, 3'd0, 40'd0, 3'd5);
    idle("R8", 0, 3'd0, 40'd0, 3'd1);
    // R9: missing entries
    doOp("R9", 1, 16'h0007, 16'h0009, 0, 0, 2'd0, 3'd7, 3'd6, 0,
         1, 3'd7, 40'h00_0000_0055, 3'd6);
    for (int i = 0; i < 8; i++) idle("R9", 1'b0, 3'd0, 40'd0, 3'(i));
    // R10: idle cycles hold resData and leave entries alone
    idle("R10", 0, 3'd0, 40'd0, 3'd0);
    idle("R10", 0, 3'd0, 40'd0, 3'd3);

    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      op = 2'($urandom);
      doOp(op < 2'd2 ? "R3" : "R4", 1'($urandom), 16'($urandom), 16'($urandom),
           1'($urandom), 1'($urandom), op, 3'($urandom), 3'($urandom),
           1'($urandom), 1'($urandom % 4 == 0), 3'($urandom),
           {8'($urandom), 32'($urandom)}, 3'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule